// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a small sum-of-products programmable logic array. It receives eight product terms from the AND plane and ORs them into one sum. It also receives a per-cell output-enable product term, a global enable pin, a clock and three configuration bits. It drives three signals: a pad data value, a pad output-enable, and a feedback bit that returns to the array.

The three configuration bits pick one of eight modes. One bit chooses between a registered path and a combinational path. One bit chooses the output polarity. One bit chooses the enable source. The register can be forced to any value through a synchronous preload path, which is intended for test. Registered mode feeds the register state back to the array, which lets the array build state machines. Combinational mode feeds back the value seen on the pad, so the pin can be used bidirectionally.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst_n` is low, the register holds 0. With `cfg_i` = 3'b100 (registered, active-low, pin enable) the pad value is therefore 1, and feedback is 0.
- R2: When `cfg_i[1]`=0 (registered), each rising clock edge without preload captures the OR of `pt_i` into the register. Between edges, the pad value and the feedback do not follow `pt_i`.
- R3: When `cfg_i[1]`=1 (combinational), the pad value follows the OR of `pt_i` with no clock edge.
- R4: `cfg_i[0]` sets polarity. A value of 1 drives the selected value unchanged. A value of 0 drives it inverted. This applies in both registered and combinational mode.
- R5: `pad_oe_o` equals `oe_pt_i` when `cfg_i[2]`=0 and equals `oe_pin_i` when `cfg_i[2]`=1. The pin enable is active-high.
- R6: `fb_o` is the register state in registered mode, and `pad_in_i` has no effect on it there. In combinational mode, `fb_o` equals `pad_in_i`.
- R7: When `preload_en_i` is high at a rising edge, the register loads `preload_val_i` in place of the product-term sum.
- R8: In the unprogrammed configuration 3'b100, the pad value is the inverted register state and the enable comes from `oe_pin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global array clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cfg_i | input | 3 | Mode bits: [2] enable source, [1] combinational, [0] active-high |
| pt_i | input | NUM_PT | Product terms from the AND plane |
| oe_pt_i | input | 1 | Per-cell enable product term |
| oe_pin_i | input | 1 | Shared enable pin, active-high |
| pad_in_i | input | 1 | Value currently seen on the pad |
| preload_en_i | input | 1 | Synchronous preload strobe |
| preload_val_i | input | 1 | Value loaded by preload |
| pad_out_o | output | 1 | Pad data value after polarity |
| pad_oe_o | output | 1 | Pad output-enable |
| fb_o | output | 1 | Feedback bit to the AND plane |

## Verification
The only internal state is the register bit. In registered mode a wrong value in it shows at once on `fb_o`, and on `pad_out_o` with the selected polarity. A wrong capture or preload therefore appears one edge after the stimulus that caused it. In combinational mode the register is hidden from the ports. For that reason the tests switch back to registered mode to read it, which exposes a capture that is missing or lands on the wrong edge.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    // Mode bits; bit order matches cfg_i[2:0]
    typedef struct packed {
        logic pin_oe;    // 1: shared pin enable, 0: product-term enable
        logic comb;      // 1: combinational path, 0: registered path
        logic act_high;  // 1: drive true value, 0: drive inverted
    } cell_cfg_t;

    localparam cell_cfg_t UNPROGRAMMED_CFG = '{pin_oe: 1'b1, comb: 1'b0, act_high: 1'b0};

    typedef struct packed {
        logic q;
    } cell_state_t;

endpackage

// File: rtl/pld_sum_plane.sv
module pld_sum_plane #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] terms_i,
    output logic              sum_o
);
    localparam int LAST = NUM_PT - 1;

    logic [NUM_PT-1:0] chain;

    assign chain[0] = terms_i[0];

    generate
        for (genvar k = 1; k < NUM_PT; k++) begin : g_or
            assign chain[k] = chain[k-1] | terms_i[k];
        end
    endgenerate

    assign sum_o = chain[LAST];
endmodule

// File: rtl/pld_oe_select.sv
module pld_oe_select (
    input  logic use_pin_i,
    input  logic oe_pt_i,
    input  logic oe_pin_i,
    output logic oe_o
);
    always_comb begin
        oe_o = use_pin_i ? oe_pin_i : oe_pt_i;
    end
endmodule

// File: rtl/pld_polarity.sv
module pld_polarity (
    input  logic act_high_i,
    input  logic val_i,
    output logic val_o
);
    always_comb begin
        val_o = act_high_i ? val_i : ~val_i;
    end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_i,
    input  logic [NUM_PT-1:0] pt_i,
    input  logic              oe_pt_i,
    input  logic              oe_pin_i,
    input  logic              pad_in_i,
    input  logic              preload_en_i,
    input  logic              preload_val_i,
    output logic              pad_out_o,
    output logic              pad_oe_o,
    output logic              fb_o
);
    cell_cfg_t   cfg;
    cell_state_t st_d, st_q;
    logic        sum;
    logic        path_val;

    assign cfg = cell_cfg_t'(cfg_i);

    pld_sum_plane #(.NUM_PT(NUM_PT)) u_sum (
        .terms_i (pt_i),
        .sum_o   (sum)
    );

    // next-state: preload wins over the product-term sum
    always_comb begin
        st_d = st_q;
        if (preload_en_i) begin
            st_d.q = preload_val_i;
        end else begin
            st_d.q = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        path_val = cfg.comb ? sum : st_q.q;
        fb_o     = cfg.comb ? pad_in_i : st_q.q;
    end

    pld_polarity u_pol (
        .act_high_i (cfg.act_high),
        .val_i      (path_val),
        .val_o      (pad_out_o)
    );

    pld_oe_select u_oe (
        .use_pin_i (cfg.pin_oe),
        .oe_pt_i   (oe_pt_i),
        .oe_pin_i  (oe_pin_i),
        .oe_o      (pad_oe_o)
    );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
    parameter int NUM_PT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_i,
    input logic [NUM_PT-1:0] pt_i,
    input logic              oe_pt_i,
    input logic              oe_pin_i,
    input logic              pad_in_i,
    input logic              preload_en_i,
    input logic              preload_val_i,
    input logic              pad_out_o,
    input logic              pad_oe_o,
    input logic              fb_o
);
    // R2
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i[1] && !preload_en_i) |=> (cfg_i[1] || fb_o == $past(|pt_i)));

    // R7
    preload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en_i |=> (cfg_i[1] || fb_o == $past(preload_val_i)));

    // R3
    comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[1] |-> ((pad_out_o ^ (|pt_i)) == !cfg_i[0]));

    // R4
    reg_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i[1] |-> ((pad_out_o ^ fb_o) == !cfg_i[0]));

    // R5
    oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (pad_oe_o == (cfg_i[2] ? oe_pin_i : oe_pt_i)));

    // R6
    comb_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[1] |-> (fb_o == pad_in_i));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NUM_PT(NUM_PT)) u_chk (.*);

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPT = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2:0]     cfg_i;
    logic [NPT-1:0] pt_i;
    logic           oe_pt_i, oe_pin_i, pad_in_i, preload_en_i, preload_val_i;
    logic           pad_out_o, pad_oe_o, fb_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pld_out_cell #(.NUM_PT(NPT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .pt_i(pt_i),
        .oe_pt_i(oe_pt_i), .oe_pin_i(oe_pin_i), .pad_in_i(pad_in_i),
        .preload_en_i(preload_en_i), .preload_val_i(preload_val_i),
        .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_i = 3'b100; pt_i = '1; oe_pt_i = 1'b0; oe_pin_i = 1'b1;
        pad_in_i = 1'b1; preload_en_i = 1'b0; preload_val_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 pad out in reset", pad_out_o, 1'b1);
        check("R1 feedback in reset", fb_o, 1'b0);
        check("R8 default enable from pin", pad_oe_o, 1'b1);
        @(negedge clk);
        pt_i = '0;
        rst_n = 1'b1;
        #1;
        check("R1 state after release", fb_o, 1'b0);
    endtask

    task automatic t_registered();
        @(negedge clk);
        cfg_i = 3'b101; pt_i = 8'b0010_0000;
        #1;
        check("R2 no change before edge", fb_o, 1'b0);
        check("R2 pad holds before edge", pad_out_o, 1'b0);
        step_edge();
        check("R2 captured one term", fb_o, 1'b1);
        check("R4 active-high registered", pad_out_o, 1'b1);
        @(negedge clk);
        pt_i = '0;
        #1;
        check("R2 holds between edges", fb_o, 1'b1);
        step_edge();
        check("R2 captured zero", fb_o, 1'b0);
        @(negedge clk);
        cfg_i = 3'b100; pt_i = 8'b1000_0001;
        step_edge();
        check("R8 default inverted state", pad_out_o, 1'b0);
        check("R8 default state", fb_o, 1'b1);
    endtask

    task automatic t_comb();
        @(negedge clk);
        cfg_i = 3'b011; pt_i = 8'b0000_0100;
        #1;
        check("R3 comb high", pad_out_o, 1'b1);
        pt_i = '0;
        #1;
        check("R3 comb low no clock", pad_out_o, 1'b0);
        cfg_i = 3'b010;
        #1;
        check("R4 comb inverted low", pad_out_o, 1'b1);
        pt_i = 8'b1111_0000;
        #1;
        check("R4 comb inverted high", pad_out_o, 1'b0);
    endtask

    task automatic t_enable();
        @(negedge clk);
        cfg_i = 3'b001; oe_pt_i = 1'b1; oe_pin_i = 1'b0;
        #1;
        check("R5 product-term enable", pad_oe_o, 1'b1);
        oe_pt_i = 1'b0;
        #1;
        check("R5 product-term disable", pad_oe_o, 1'b0);
        cfg_i = 3'b101; oe_pin_i = 1'b1;
        #1;
        check("R5 pin enable", pad_oe_o, 1'b1);
        oe_pin_i = 1'b0; oe_pt_i = 1'b1;
        #1;
        check("R5 pin disable", pad_oe_o, 1'b0);
    endtask

    task automatic t_feedback();
        @(negedge clk);
        cfg_i = 3'b011; pad_in_i = 1'b0; pt_i = '1;
        #1;
        check("R6 comb fb pad low", fb_o, 1'b0);
        pad_in_i = 1'b1;
        #1;
        check("R6 comb fb pad high", fb_o, 1'b1);
        // register keeps capturing while in comb mode; read it back in registered mode
        pt_i = '0;
        step_edge();
        @(negedge clk);
        cfg_i = 3'b001; pad_in_i = 1'b1;
        #1;
        check("R6 registered fb ignores pad", fb_o, 1'b0);
    endtask

    task automatic t_preload();
        @(negedge clk);
        cfg_i = 3'b001; pt_i = '0; preload_en_i = 1'b1; preload_val_i = 1'b1;
        step_edge();
        check("R7 preload over zero sum", fb_o, 1'b1);
        @(negedge clk);
        pt_i = '1; preload_val_i = 1'b0;
        step_edge();
        check("R7 preload over one sum", fb_o, 1'b0);
        @(negedge clk);
        preload_en_i = 1'b0;
        step_edge();
        check("R7 normal capture resumes", fb_o, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_registered();
        t_comb();
        t_enable();
        t_feedback();
        t_preload();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule